// File: doc/BRIEF.md
# Converter Loopback Self-Test Sequencer

This block checks a digital-to-analog converter and an analog-to-digital converter that are wired back to back. It works through a fixed internal sequence of test codes. For each code it does the following:

- It places the code on the DAC input.
- It waits a settling delay.
- It pulses a conversion request to the ADC and waits for the converted result.
- It compares the result with the applied code.

If the result is close enough to the code, it moves to the next code once the test period has run out. If it is not, it stops and raises an error flag. It then holds the failing code and the returned value for inspection.

A host pulses `startReq` to begin a run. It then sees an endless series of passes, each counted in `passCount`, until a mismatch halts the run. A halted sequencer restarts on the next start request. The analog parts sit outside the block.

Top module: `loopTestSeq`

## Requirements
- R1: After reset the outputs are as follows: `running`, `errFlag` and `adcStart` are 0. `passCount`, `failCode` and `failData` are 0. `dacCode` shows the code at index 0.
- R2: The code at index i is i*floor((2^CODE_W-1)/(NUM_CODES-1)), for i from 0 to NUM_CODES-1. Codes are applied in rising index order, and every run begins at index 0.
- R3: A start request seen while idle or halted begins a run. It clears `errFlag`, `failCode`, `failData` and `passCount`. A start request seen while a run is active has no effect on the code order or the timing.
- R4: `adcStart` is a pulse one clock wide. It rises SETTLE_CYCLES clock cycles after the cycle in which a new test period starts.
- R5: One ADC request is made per test period. If the converter answers within CYCLE_LEN-SETTLE_CYCLES-2 cycles of the request, consecutive requests are exactly CYCLE_LEN cycles apart.
- R6: On `adcDone`, the value |adcData - dacCode| is computed as an unsigned magnitude. A result less than or equal to `tolerance` lets the run continue. A larger result halts the run, and `errFlag` is high in the cycle after `adcDone`.
- R7: While halted, `running` and `adcStart` stay 0 and `dacCode` does not change. `failCode` and `failData` hold the code and data of the failed comparison until reset or a restart.
- R8: Each time the index wraps from NUM_CODES-1 to 0, `passCount` increases by one and testing continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Begin (or restart) a test run |
| tolerance | input | CODE_W | Largest allowed absolute difference |
| adcDone | input | 1 | ADC result valid, one cycle |
| adcData | input | CODE_W | Converted result from the ADC |
| dacCode | output | CODE_W | Test code driven to the DAC |
| adcStart | output | 1 | Conversion request pulse |
| running | output | 1 | A run is in progress |
| errFlag | output | 1 | Halted on a tolerance violation |
| failCode | output | CODE_W | Code applied when the failure occurred |
| failData | output | CODE_W | Value returned when the failure occurred |
| passCount | output | PASS_W | Completed passes through the program |

## Verification
The first conversion request is due SETTLE_CYCLES cycles after the clock edge that accepts the start request. Each later request follows CYCLE_LEN cycles after the one before. The bench keeps a cycle counter and compares the falling-edge cycle at which `adcStart` is seen against that expected count. The pass/halt decision, `errFlag` and the captured values are due one edge after `adcDone`, so they are sampled on the falling edge that follows it. Conversion latency, injected error and tolerance are drawn from a seeded random source. Directed cases cover both sides of the tolerance boundary, clamped data at the code extremes, and a start request made mid-run.

// File: rtl/loopTestPkg.sv
package loopTestPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_KICK,
    ST_WAIT,
    ST_HOLD,
    ST_HALT
  } seqStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;  // new run: reset pointer, counters, capture
    logic advance;   // move to next test code
    logic capture;   // latch failing code and data
  } strobeT;

endpackage

// File: rtl/loopTestCtrl.sv
module loopTestCtrl
  import loopTestPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   adcDone,
  input  logic   settleDone,
  input  logic   cycleDone,
  input  logic   outOfTol,
  output strobeT strb,
  output logic   adcStart,
  output logic   running,
  output logic   errFlag
);

  seqStateT state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_IDLE, ST_HALT: begin
        if (startReq) begin
          strb.clearAll = 1'b1;
          nextState     = ST_SETTLE;
        end
      end
      ST_SETTLE: if (settleDone) nextState = ST_KICK;
      ST_KICK:   nextState = ST_WAIT;
      ST_WAIT: begin
        if (adcDone) begin
          if (outOfTol) begin
            strb.capture = 1'b1;
            nextState    = ST_HALT;
          end else begin
            nextState = ST_HOLD;
          end
        end
      end
      ST_HOLD: begin
        if (cycleDone) begin
          strb.advance = 1'b1;
          nextState    = ST_SETTLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign adcStart = (state == ST_KICK);
  assign errFlag  = (state == ST_HALT);
  assign running  = (state != ST_IDLE) && (state != ST_HALT);

endmodule

// File: rtl/loopTestDp.sv
module loopTestDp
  import loopTestPkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int NUM_CODES     = 8,
  parameter int SETTLE_CYCLES = 4,
  parameter int CYCLE_LEN     = 16,
  parameter int PASS_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [CODE_W-1:0] tolerance,
  input  logic [CODE_W-1:0] adcData,
  output logic [CODE_W-1:0] dacCode,
  output logic              settleDone,
  output logic              cycleDone,
  output logic              outOfTol,
  output logic [CODE_W-1:0] failCode,
  output logic [CODE_W-1:0] failData,
  output logic [PASS_W-1:0] passCount
);

  localparam int IDX_W = (NUM_CODES > 1) ? $clog2(NUM_CODES) : 1;
  localparam int CNT_W = $clog2(CYCLE_LEN + 1);
  localparam int STEP  = (NUM_CODES > 1) ? ((1 << CODE_W) - 1) / (NUM_CODES - 1) : 0;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CODES - 1);

  // evenly spaced ramp of test codes
  logic [CODE_W-1:0] codeTbl [NUM_CODES];
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    assign codeTbl[g] = CODE_W'(g * STEP);
  end

  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] cycCnt;
  logic             lastCode;

  assign dacCode    = codeTbl[ptr];
  assign lastCode   = (ptr == LAST_IDX);
  assign settleDone = (cycCnt == CNT_W'(SETTLE_CYCLES - 1));
  assign cycleDone  = (cycCnt == CNT_W'(CYCLE_LEN - 1));

  // period counter, saturating at the end of the period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cycCnt <= '0;
    else if (strb.clearAll || strb.advance) cycCnt <= '0;
    else if (!cycleDone)                  cycCnt <= cycCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      passCount <= '0;
    end else if (strb.clearAll) begin
      ptr       <= '0;
      passCount <= '0;
    end else if (strb.advance) begin
      if (lastCode) begin
        ptr       <= '0;
        passCount <= passCount + 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // absolute difference against tolerance
  logic signed [CODE_W:0] diff;
  logic        [CODE_W:0] mag;
  assign diff     = $signed({1'b0, adcData}) - $signed({1'b0, dacCode});
  assign mag      = diff[CODE_W] ? CODE_W'(-diff) : diff;
  assign outOfTol = mag > {1'b0, tolerance};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failCode <= '0;
      failData <= '0;
    end else if (strb.clearAll) begin
      failCode <= '0;
      failData <= '0;
    end else if (strb.capture) begin
      failCode <= dacCode;
      failData <= adcData;
    end
  end

endmodule

// File: rtl/loopTestSeq.sv
module loopTestSeq
  import loopTestPkg::*;
#(
  parameter int CODE_W        = 8,
  parameter int NUM_CODES     = 8,
  parameter int SETTLE_CYCLES = 4,
  parameter int CYCLE_LEN     = 16,
  parameter int PASS_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CODE_W-1:0] tolerance,
  input  logic              adcDone,
  input  logic [CODE_W-1:0] adcData,
  output logic [CODE_W-1:0] dacCode,
  output logic              adcStart,
  output logic              running,
  output logic              errFlag,
  output logic [CODE_W-1:0] failCode,
  output logic [CODE_W-1:0] failData,
  output logic [PASS_W-1:0] passCount
);

  strobeT strb;
  logic   settleDone, cycleDone, outOfTol;

  loopTestCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .adcDone(adcDone),
    .settleDone(settleDone), .cycleDone(cycleDone), .outOfTol(outOfTol),
    .strb(strb), .adcStart(adcStart), .running(running), .errFlag(errFlag)
  );

  loopTestDp #(
    .CODE_W(CODE_W), .NUM_CODES(NUM_CODES), .SETTLE_CYCLES(SETTLE_CYCLES),
    .CYCLE_LEN(CYCLE_LEN), .PASS_W(PASS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tolerance(tolerance), .adcData(adcData),
    .dacCode(dacCode), .settleDone(settleDone), .cycleDone(cycleDone),
    .outOfTol(outOfTol), .failCode(failCode), .failData(failData),
    .passCount(passCount)
  );

endmodule

// File: rtl/loopTestChk.sv
module loopTestChk #(
  parameter int CODE_W = 8,
  parameter int PASS_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              startReq,
  input logic              adcDone,
  input logic              adcStart,
  input logic              running,
  input logic              errFlag,
  input logic [CODE_W-1:0] failCode,
  input logic [CODE_W-1:0] failData,
  input logic [PASS_W-1:0] passCount
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  // R4
  adc_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  // R7
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!running && !adcStart));

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !startReq) |=> (errFlag && $stable(failCode) && $stable(failData)));

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $rose(errFlag)) |-> $past(adcDone));

  // R8
  pass_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && (passCount != $past(passCount))) |->
      ((passCount == PASS_W'($past(passCount) + 1'b1)) || (passCount == '0)));

endmodule

bind loopTestSeq loopTestChk #(.CODE_W(CODE_W), .PASS_W(PASS_W)) u_chk (
  .clk(clk), .rstN(rstN), .startReq(startReq), .adcDone(adcDone),
  .adcStart(adcStart), .running(running), .errFlag(errFlag),
  .failCode(failCode), .failData(failData), .passCount(passCount)
);

// File: tb/test_loopTestSeq.sv
module test_loopTestSeq;
  localparam int W    = 8;
  localparam int N    = 8;
  localparam int S    = 4;
  localparam int L    = 16;
  localparam int P    = 8;
  localparam int STEP = ((1 << W) - 1) / (N - 1);

  logic         clk = 1'b0, rstN = 1'b0, startReq = 1'b0, adcDone = 1'b0;
  logic [W-1:0] tolerance = '0, adcData = '0;
  logic [W-1:0] dacCode, failCode, failData;
  logic [P-1:0] passCount;
  logic         adcStart, running, errFlag;

  int checks = 0, fails = 0, cyc = 0;
  int expIdx = 0, expPass = 0, expKick = 0;

  loopTestSeq #(.CODE_W(W), .NUM_CODES(N), .SETTLE_CYCLES(S), .CYCLE_LEN(L), .PASS_W(P))
  i_loopTestSeq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .tolerance(tolerance),
    .adcDone(adcDone), .adcData(adcData), .dacCode(dacCode), .adcStart(adcStart),
    .running(running), .errFlag(errFlag), .failCode(failCode), .failData(failData),
    .passCount(passCount)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int codeOf(int i);
    return i * STEP;
  endfunction

  function automatic int clampv(int v);
    return (v < 0) ? 0 : ((v > (1 << W) - 1) ? (1 << W) - 1 : v);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // R3: start (or restart) a run from idle or halt
  task automatic pulseStart;
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    expIdx  = 0;
    expPass = 0;
    expKick = cyc + S;
    chk(errFlag == 1'b0 && running == 1'b1, "R3", "run active, error cleared",
        {errFlag, running}, 1);
    chk(failCode == 0 && failData == 0 && passCount == 0, "R3", "capture/pass cleared",
        failCode + failData + passCount, 0);
  endtask

  // one conversion: err injected, lat cycles of latency, optional mid-run start
  task automatic convert(int err, int lat, bit poke, output bit failed);
    int t = 0;
    int code, data, diff, holdCode, holdData;
    bit sawKick;
    while (!adcStart && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(adcStart && cyc == expKick, "R5", "request cycle", cyc, expKick);
    chk(dacCode == codeOf(expIdx), "R2", "applied code", dacCode, codeOf(expIdx));
    chk(passCount == expPass, "R8", "pass count", passCount, expPass);
    code = dacCode;
    @(negedge clk);
    chk(!adcStart, "R4", "request pulse width", adcStart, 0);
    if (poke) begin
      startReq = 1'b1;
      @(negedge clk) startReq = 1'b0;
      repeat (lat - 2) @(negedge clk);
    end else begin
      repeat (lat - 1) @(negedge clk);
    end
    data    = clampv(code + err);
    adcData = W'(data);
    adcDone = 1'b1;
    @(negedge clk) adcDone = 1'b0;
    diff   = (data > code) ? data - code : code - data;
    failed = (diff > int'(tolerance));
    chk(errFlag == failed, "R6", "decision vs tolerance", errFlag, failed);
    if (failed) begin
      chk(running == 0 && failCode == code && failData == data, "R7", "captured code",
          failCode, code);
      chk(failData == data, "R7", "captured data", failData, data);
      holdCode = dacCode;
      holdData = failData;
      sawKick  = 0;
      repeat (2 * L) begin
        @(negedge clk);
        if (adcStart || running || dacCode != holdCode) sawKick = 1;
      end
      chk(!sawKick && errFlag && failData == holdData, "R7", "halt held", sawKick, 0);
    end else begin
      chk(running == 1'b1, "R6", "continues after pass", running, 1);
      expIdx++;
      if (expIdx == N) begin
        expIdx = 0;
        expPass++;
      end
      expKick += L;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    bit f;
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!running && !errFlag && !adcStart, "R1", "control outputs idle",
        {running, errFlag, adcStart}, 0);
    chk(passCount == 0 && failCode == 0 && failData == 0, "R1", "counters clear",
        passCount + failCode + failData, 0);
    chk(dacCode == codeOf(0), "R1", "initial code", dacCode, codeOf(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!running && !adcStart, "R1", "stays idle without start", running, 0);

    // R2/R5/R8: exact-match run over two full passes, tolerance 0
    tolerance = 0;
    pulseStart();
    for (int i = 0; i < 2 * N; i++) begin
      // R3: a start request mid-run on conversion 5 is ignored
      convert(0, (i == 5) ? 3 : 1 + int'($urandom_range(5)), i == 5, f);
    end

    // R6 tolerance boundary: +3 and -3 pass, +4 fails
    tolerance = 3;
    convert(3, 2, 0, f);
    convert(-3, 4, 0, f);
    convert(4, 1, 0, f);
    chk(f == 1, "R6", "boundary tol+1 halts", f, 1);

    // R3 restart; clamped data at code 0 passes (|0-0| = 0)
    tolerance = 5;
    pulseStart();
    convert(-6, 2, 0, f);
    chk(f == 0, "R6", "clamped low data passes", f, 0);

    // random phase
    for (int run = 0; run < 4; run++) begin
      tolerance = W'($urandom_range(6));
      if (errFlag || !running) pulseStart();
      for (int i = 0; i < 3 * N; i++) begin
        int e;
        e = int'($urandom_range(2 * int'(tolerance) + 4)) - int'(tolerance) - 2;
        convert(e, 1 + int'($urandom_range(5)), 0, f);
        if (f) break;
      end
    end
    summary();
  end
endmodule